// File: doc/BRIEF.md
# PHY Event Interrupt Status and Enable Register

This block is a 16-bit management register that gathers eight event indications from the physical-layer logic into sticky status flags and turns them into one interrupt line. The events are jabber detection, receive error, page reception during auto-negotiation, parallel detect fault, link partner acknowledge, link status change, remote fault and auto-negotiation completion. The low byte holds the flags. The high byte holds one enable per flag. The interrupt is raised when any flag is set and its enable is set.

Software reaches the register through a plain strobe port, the kind a serial management front end would drive. A read returns enables and flags together, and the same read clears every flag. A write loads only the enable byte. The flags set whether or not they are enabled, so the register works for polling as well as for interrupts. Receive error is caught on its rising edge only. Link status is caught on a change in either direction. All other event inputs set their flag in every cycle they are high.

Top module: `phy_irq_status_reg`

## Requirements
- R1: Read data bit 7 is jabber, bit 6 receive error, bit 5 page received, bit 4 parallel detect fault, bit 3 link partner acknowledge, bit 2 link status change, bit 1 remote fault and bit 0 auto-negotiation complete. Bits 15 to 8 are the enables, and bit k+8 enables flag k.
- R2: A write strobe loads wr_data[15:8] into the enables at the clock edge. With no write, the enables keep their value.
- R3: A flag sets at the clock edge after its event is seen and stays set until a read. The flag sets whether or not its enable is one.
- R4: rd_data always shows the current register contents, so in the read cycle it returns the value from before the clear. At the edge that ends the read, all eight flags clear.
- R5: An event seen in the same cycle as a read leaves its flag set after that read.
- R6: The receive error flag sets only when rx_err goes from 0 to 1. Holding rx_err high sets nothing more.
- R7: The link status change flag sets on any change of link_ok, whether it falls or rises.
- R8: A write leaves all eight flags unchanged, and wr_data[7:0] is ignored.
- R9: irq is a registered active-high level. It is one in the cycle after a cycle in which some flag and its enable were both one.
- R10: A synchronous active-low reset clears all sixteen bits and irq. If rx_err or link_ok is held high through reset, no flag sets when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock; all inputs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read strobe; clears the flags at the clock edge |
| wr_stb | input | 1 | Write strobe; loads the enable byte |
| wr_data | input | 16 | Write data; only bits 15:8 are used |
| ev_jabber | input | 1 | Jabber detected |
| rx_err | input | 1 | Receive error level (rising edge sets the flag) |
| ev_page_rx | input | 1 | Page received from link partner |
| ev_pd_fault | input | 1 | Parallel detect fault |
| ev_lp_ack | input | 1 | Link partner acknowledge seen |
| link_ok | input | 1 | Link status level (either edge sets the flag) |
| ev_remote_fault | input | 1 | Remote fault detected |
| ev_an_done | input | 1 | Auto-negotiation complete |
| rd_data | output | 16 | Enables in 15:8, flags in 7:0 |
| irq | output | 1 | Registered interrupt level |

## Verification
Embedded assertions check on every cycle that flags never drop unless a read occurs, that enables move only on a write, that a steady-high receive error sets nothing, that any link change leaves its flag set, and that irq follows the previous cycle's enabled flags. The bench's cycle-accurate model and directed scenarios show what properties cannot show well: the bit order of each event, the value read before a clear, an event that arrives during a read, the ignored low byte of a write, and quiet reset release with level inputs held high.

// File: rtl/phy_isr_pkg.sv
// Package: shared sizes, flag positions and trigger kinds for the PHY
// interrupt status register. Assumes eight events, one per status bit.
package phy_isr_pkg;

    localparam int NUM_EV   = 8;
    localparam int REG_W    = 2 * NUM_EV;

    localparam int B_JABBER = 7;
    localparam int B_RXERR  = 6;
    localparam int B_PAGE   = 5;
    localparam int B_PDF    = 4;
    localparam int B_LPACK  = 3;
    localparam int B_LINK   = 2;
    localparam int B_RFAULT = 1;
    localparam int B_ANDONE = 0;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_ANY   = 2'd2
    } trig_e;

    // Trigger kind for each status bit position.
    function automatic trig_e trig_of(input int bitpos);
        if (bitpos == B_RXERR)     return TRIG_RISE;
        else if (bitpos == B_LINK) return TRIG_ANY;
        else                       return TRIG_LEVEL;
    endfunction

endpackage

// File: rtl/isr_edge_capture.sv
// Module: turns raw event inputs into per-cycle set requests.
// Level-triggered bits pass straight through. Rise and any-edge bits
// compare against a one-cycle delayed copy, which is loaded from the
// input during reset so that reset release shows no false edge.
// Assumes all inputs are synchronous to clk.
module isr_edge_capture
    import phy_isr_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] hit
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (trig_of(i) == TRIG_LEVEL) begin : g_level
            assign hit[i] = raw[i];
        end else begin : g_edge
            logic dly;

            // Delayed copy; follows the input during and after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) dly <= raw[i];
                else        dly <= raw[i];
            end

            if (trig_of(i) == TRIG_RISE) begin : g_rise
                assign hit[i] = raw[i] & ~dly;
            end else begin : g_any
                assign hit[i] = raw[i] ^ dly;
            end
        end
    end

endmodule

// File: rtl/isr_status_bank.sv
// Module: sticky status flags. A flag sets on its hit and holds until
// a clearing read. A hit in the read cycle wins over the clear.
module isr_status_bank
    import phy_isr_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic         rd_clr,
    output logic [N-1:0] status
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: set on hit, cleared by a read without a hit.
        always_ff @(posedge clk) begin
            if (!rst_n)       status[i] <= 1'b0;
            else if (hit[i])  status[i] <= 1'b1;
            else if (rd_clr)  status[i] <= 1'b0;
        end
    end

    // Flags only drop on a read (R3).
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((status & $past(status)) == $past(status)));

    // A hit during a read survives it (R5).
    assert_hit_survives_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (hit != '0)) |=> ((status & $past(hit)) == $past(hit)));

endmodule

// File: rtl/isr_enable_reg.sv
// Module: the enable byte. It loads from the write data on a write
// strobe and holds otherwise.
module isr_enable_reg
    import phy_isr_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en
);

    // Enable storage, loaded only by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= wdata;
    end

    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en));

endmodule

// File: rtl/isr_irq_gen.sv
// Module: registered interrupt level. irq is high in the cycle after
// any flag and its enable were both one.
module isr_irq_gen
    import phy_isr_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status,
    input  logic [N-1:0] en,
    output logic         irq
);

    logic pend;
    assign pend = |(status & en);

    // Output register for the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= pend;
    end

endmodule

// File: rtl/phy_irq_status_reg.sv
// Module: top of the PHY interrupt status/enable register. It captures
// eight events as sticky flags (low byte), holds per-flag enables (high
// byte) and drives a registered interrupt. A read returns the whole
// register and clears the flags. A write loads only the enables.
// Assumes the strobes and events are synchronous to clk.
module phy_irq_status_reg
    import phy_isr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ev_jabber,
    input  logic             rx_err,
    input  logic             ev_page_rx,
    input  logic             ev_pd_fault,
    input  logic             ev_lp_ack,
    input  logic             link_ok,
    input  logic             ev_remote_fault,
    input  logic             ev_an_done,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);

    ev_vec_t raw_ev;
    ev_vec_t hit;
    ev_vec_t status;
    ev_vec_t en;

    // Place each event at its register bit.
    always_comb begin
        raw_ev           = '0;
        raw_ev[B_JABBER] = ev_jabber;
        raw_ev[B_RXERR]  = rx_err;
        raw_ev[B_PAGE]   = ev_page_rx;
        raw_ev[B_PDF]    = ev_pd_fault;
        raw_ev[B_LPACK]  = ev_lp_ack;
        raw_ev[B_LINK]   = link_ok;
        raw_ev[B_RFAULT] = ev_remote_fault;
        raw_ev[B_ANDONE] = ev_an_done;
    end

    isr_edge_capture #(.N(NUM_EV)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_ev),
        .hit   (hit)
    );

    isr_status_bank #(.N(NUM_EV)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .rd_clr (rd_stb),
        .status (status)
    );

    isr_enable_reg #(.N(NUM_EV)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_stb),
        .wdata (wr_data[REG_W-1:NUM_EV]),
        .en    (en)
    );

    isr_irq_gen #(.N(NUM_EV)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .en     (en),
        .irq    (irq)
    );

    assign rd_data = {en, status};

    // A steady-high receive error sets nothing (R6).
    assert_rxerr_level_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && $past(rx_err) && !rd_stb) |=> (status[B_RXERR] == $past(status[B_RXERR])));

    // Any change of link_ok leaves the link flag set (R7).
    assert_link_change_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ok != $past(link_ok)) |=> status[B_LINK]);

    // irq follows the previous cycle's enabled flags seen on rd_data (R9).
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(rd_data[REG_W-1:NUM_EV] & rd_data[NUM_EV-1:0])));

endmodule

// File: tb/phy_irq_status_reg_bench.sv
`timescale 1ns/1ps
module phy_irq_status_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ev_jabber = 1'b0, rx_err = 1'b0, ev_page_rx = 1'b0, ev_pd_fault = 1'b0;
    logic        ev_lp_ack = 1'b0, link_ok = 1'b0, ev_remote_fault = 1'b0, ev_an_done = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    always #2 clk = ~clk;

    phy_irq_status_reg u_phy_irq_status_reg (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
        .ev_jabber(ev_jabber), .rx_err(rx_err), .ev_page_rx(ev_page_rx),
        .ev_pd_fault(ev_pd_fault), .ev_lp_ack(ev_lp_ack), .link_ok(link_ok),
        .ev_remote_fault(ev_remote_fault), .ev_an_done(ev_an_done),
        .rd_data(rd_data), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit [7:0] m_st = '0, m_en = '0;
    bit       m_irq = 1'b0, m_rxd = 1'b0, m_lkd = 1'b0;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog R1 actual=%0d cycles expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference, advanced once per rising edge.
    task automatic model_tick();
        bit [7:0] setv;
        setv = {ev_jabber, rx_err & ~m_rxd, ev_page_rx, ev_pd_fault,
                ev_lp_ack, link_ok ^ m_lkd, ev_remote_fault, ev_an_done};
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_irq = 1'b0;
        end else begin
            m_irq = |(m_st & m_en);
            m_st  = rd_stb ? setv : (m_st | setv);
            if (wr_stb) m_en = wr_data[15:8];
        end
        m_rxd = rx_err;
        m_lkd = link_ok;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk({tag, " rd_data"}, rd_data, {m_en, m_st});
        chk({tag, " irq"}, {15'd0, irq}, {15'd0, m_irq});
    endtask

    task automatic quiet();
        ev_jabber = 0; ev_page_rx = 0; ev_pd_fault = 0; ev_lp_ack = 0;
        ev_remote_fault = 0; ev_an_done = 0; rd_stb = 0; wr_stb = 0; wr_data = '0;
    endtask

    task automatic do_read(string tag);
        rd_stb = 1; step(tag); rd_stb = 0;
    endtask

    initial begin
        // R10: reset with level inputs held high.
        rx_err = 1; link_ok = 1;
        repeat (3) step("R10 in reset");
        @(negedge clk); rst_n = 1;
        repeat (3) step("R10 after release");
        chk("R10 zero", rd_data, 16'h0000);

        // R1 / R3: each pulse event alone, no enables.
        ev_jabber = 1;   step("R1 jabber");  quiet(); chk("R1 jabber bit7", rd_data, 16'h0080);
        step("R3 sticky"); chk("R3 held", rd_data, 16'h0080);
        do_read("R4 read"); chk("R4 cleared", rd_data, 16'h0000);
        ev_page_rx = 1;  step("R1 page");    quiet(); chk("R1 page bit5", rd_data, 16'h0020);
        do_read("R4 read");
        ev_pd_fault = 1; step("R1 pdf");     quiet(); chk("R1 pdf bit4", rd_data, 16'h0010);
        do_read("R4 read");
        ev_lp_ack = 1;   step("R1 lpack");   quiet(); chk("R1 lpack bit3", rd_data, 16'h0008);
        do_read("R4 read");
        ev_remote_fault = 1; step("R1 rfault"); quiet(); chk("R1 rfault bit1", rd_data, 16'h0002);
        do_read("R4 read");
        ev_an_done = 1;  step("R1 an");      quiet(); chk("R1 an bit0", rd_data, 16'h0001);
        do_read("R4 read"); chk("R4 cleared", rd_data, 16'h0000);

        // R6: rising edge only.
        rx_err = 0; step("R6 low");
        rx_err = 1; step("R6 rise"); chk("R6 set bit6", rd_data, 16'h0040);
        do_read("R6 read");
        repeat (4) step("R6 hold high");
        chk("R6 no set on level", rd_data, 16'h0000);

        // R7: both directions.
        link_ok = 0; step("R7 fall"); chk("R7 fall bit2", rd_data, 16'h0004);
        do_read("R7 read"); chk("R7 cleared", rd_data, 16'h0000);
        link_ok = 1; step("R7 rise"); chk("R7 rise bit2", rd_data, 16'h0004);
        do_read("R7 read");

        // R2 / R8: write loads enables only.
        ev_jabber = 1; step("R8 prep"); quiet();
        wr_stb = 1; wr_data = 16'hA500; step("R2 write"); quiet();
        chk("R2 enables", rd_data, 16'hA580);
        wr_stb = 1; wr_data = 16'hA5FF; step("R8 write low"); quiet();
        chk("R8 low byte ignored", rd_data, 16'hA580);
        step("R9 jabber enabled");
        chk("R9 irq high", {15'd0, irq}, 16'h0001);
        do_read("R9 read");
        step("R9 after clear");
        chk("R9 irq low", {15'd0, irq}, 16'h0000);

        // R9: disabled flag gives no irq; enabled one does, a cycle later.
        ev_remote_fault = 1; step("R9 rfault masked"); quiet();
        step("R9 masked"); chk("R9 masked irq", {15'd0, irq}, 16'h0000);
        do_read("R9 read");
        ev_page_rx = 1; step("R9 page"); quiet();
        chk("R9 not yet", {15'd0, irq}, 16'h0000);
        step("R9 page irq"); chk("R9 page irq", {15'd0, irq}, 16'h0001);
        do_read("R9 read");

        // R5: event during a read.
        ev_jabber = 1; step("R5 prep"); quiet();
        rd_stb = 1; ev_an_done = 1;
        chk("R4 pre-clear value", rd_data, 16'hA580);
        step("R5 collide"); quiet();
        chk("R5 kept", rd_data, 16'hA501);
        do_read("R5 read");

        // Mixed random traffic against the model.
        for (int i = 0; i < 400; i++) begin
            ev_jabber = ($urandom % 8) == 0; ev_page_rx = ($urandom % 8) == 0;
            ev_pd_fault = ($urandom % 8) == 0; ev_lp_ack = ($urandom % 8) == 0;
            ev_remote_fault = ($urandom % 8) == 0; ev_an_done = ($urandom % 8) == 0;
            rx_err = ($urandom % 3) == 0; link_ok = ($urandom % 4) != 0;
            rd_stb = ($urandom % 5) == 0; wr_stb = ($urandom % 9) == 0;
            wr_data = 16'($urandom);
            step("R3 R4 R5 R9 random");
        end
        quiet();
        step("R4 end");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule